// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block is the per-cycle engine of a four-channel DMA controller. Each channel keeps a base and a current address, a base and a current count, and a mode word. A channel is started from its hardware request, a software request bit and its mask. On every service tick the engine picks the lowest-numbered channel that may move data. It issues one byte or word transfer as a set of read and write strobes toward memory and the device, then steps that channel's address and counts it down.

A transfer sequence ends on terminal count (the count underflowing past its base), on an external end request, or when the hardware request is gone at the moment of a transfer. Ending clears the channel's started state and its software request. The wait cost of each transfer is reported, and a one-cycle terminal-count pulse is given per channel. Channel setup arrives through a plain write port (`cfg_*`). The actual bus cycles are performed by logic outside the block, which follows the strobes.

Top module: `dma_xfer_seq`

## Requirements
- R1: A channel becomes started on the clock edge after the term (mask low AND (hardware request OR software request bit) AND transfers enabled) goes from 0 to 1. It is cleared as soon as that term is 0. A masked channel never transfers.
- R2: While `xfer_disable` is 1, no transfer is issued. When it returns to 0, channels whose start term is now true become started on the next edge.
- R3: `cfg_mode[2:1]` selects the strobes of a transfer as {mem_rd,mem_wr,dev_rd,dev_wr}: 00 verify = 1010, 01 device to memory = 0110, 10 memory to device = 1001.
- R4: After each transfer the current address increases by 1 when `cfg_mode[0]`=0 (byte) and by 2 when it is 1 (word). No mode bit makes it decrease.
- R5: With `wrap_en`=1 the address increment is modulo 2^24 and bits 31:24 stay unchanged. With `wrap_en`=0 all 32 bits increment.
- R6: The current count decrements per transfer. The transfer after which it becomes greater than the base count drives that channel's bit of `tc_pulse` for one cycle with the transfer and ends the channel.
- R7: `cfg_mode[4:3]`=11 (cascade) or `cfg_mode[2:1]`=11 (memory to memory) never produces a transfer.
- R8: An `end_req` bit ends its started channel at once with no terminal-count pulse, unless `cfg_mode[4:3]`=01 (single), where `end_req` has no effect.
- R9: A transfer made while the channel's hardware request is low ends the channel and clears its software request bit, so a software-only request yields one transfer.
- R10: Each transfer reports `wait_cycles` of 5 when `fast_timing`=1 and 7 otherwise; the value is 0 when idle.
- R11: At most one transfer per service tick, granted to the lowest-numbered eligible channel. Outputs appear on the edge that samples `svc_tick`.
- R12: A channel whose current count is greater than its base count does not transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the selected channel's setup |
| cfg_ch | input | 2 | Channel selected by cfg_we |
| cfg_addr | input | 32 | Base and current address to load |
| cfg_count | input | 16 | Base and current count to load |
| cfg_mode | input | 5 | [4:3] transfer mode, [2:1] direction, [0] word |
| xfer_disable | input | 1 | Global transfer disable |
| fast_timing | input | 1 | Selects the shorter wait cost |
| wrap_en | input | 1 | 24-bit address wrap |
| svc_tick | input | 1 | Service cycle strobe |
| hw_req | input | 4 | Hardware requests per channel |
| sw_req_set | input | 4 | Sets software request bits |
| mask | input | 4 | Channel masks |
| end_req | input | 4 | External end requests |
| xfer_valid | output | 1 | A transfer was issued |
| xfer_ch | output | 2 | Channel of the transfer |
| xfer_word | output | 1 | Transfer is 16-bit |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| xfer_addr | output | 32 | Memory address of the transfer |
| wait_cycles | output | 3 | Wait cost of the transfer |
| tc_pulse | output | 4 | Terminal count per channel |
| ch_started | output | 4 | Started state per channel |

## Verification
The assertions assume that `svc_tick` and `xfer_disable` are plain levels sampled at the edge, and that a channel's setup is never rewritten in a cycle where it is also granted. The stimulus keeps to this by changing inputs only just after a clock edge. It loads a channel only while all hardware requests are low and `svc_tick` is 0. It also drops every request and lets one idle cycle pass before the next scenario, so each start term rises from a known low.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned WRAP_W = 24;
    parameter int unsigned WAIT_W = 3;

    localparam logic [WAIT_W-1:0] WAIT_FAST = WAIT_W'(5);
    localparam logic [WAIT_W-1:0] WAIT_SLOW = WAIT_W'(7);

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_BLOCK   = 2'b10,
        XM_CASCADE = 2'b11
    } xmode_e;

    typedef enum logic [1:0] {
        DIR_VERIFY  = 2'b00,
        DIR_TO_MEM  = 2'b01,
        DIR_TO_DEV  = 2'b10,
        DIR_MEM2MEM = 2'b11
    } dir_e;

    typedef struct packed {
        xmode_e xm;
        dir_e   dir;
        logic   word;
    } mode_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic dev_rd;
        logic dev_wr;
    } strobe_t;

    function automatic strobe_t dir_strobes(dir_e d);
        strobe_t s;
        s = '0;
        case (d)
            DIR_VERIFY: begin s.mem_rd = 1'b1; s.dev_rd = 1'b1; end
            DIR_TO_MEM: begin s.dev_rd = 1'b1; s.mem_wr = 1'b1; end
            DIR_TO_DEV: begin s.mem_rd = 1'b1; s.dev_wr = 1'b1; end
            default:    s = '0;
        endcase
        return s;
    endfunction

    // Always forward: +1 for bytes, +2 for words; wrap keeps the top byte.
    function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a,
                                                    logic word, logic wrap);
        logic [ADDR_W-1:0] inc;
        logic [ADDR_W-1:0] full;
        inc  = {{(ADDR_W-2){1'b0}}, word, ~word};
        full = a + inc;
        if (wrap)
            return {a[ADDR_W-1:WRAP_W], full[WRAP_W-1:0]};
        return full;
    endfunction

endpackage

// File: rtl/dma_pick.sv
module dma_pick #(
    parameter int NCH   = 4,
    parameter int IDX_W = 2
) (
    input  logic [NCH-1:0]   req,
    output logic [NCH-1:0]   grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  mode_t             cfg_mode,
    input  logic              hw_req,
    input  logic              sw_set,
    input  logic              mask,
    input  logic              end_req,
    input  logic              xfer_disable,
    input  logic              wrap_en,
    input  logic              grant,
    output logic              elig,
    output logic [ADDR_W-1:0] cur_addr,
    output mode_t             mode_o,
    output logic              tc_hit,
    output logic              started
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    mode_t             mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q, base_q, cnt_dec;
    logic              started_q, sreq_q, cond_q;
    logic              cond, kill, no_data, under, end_seq, single;

    always_comb begin
        single  = (mode_q.xm == XM_SINGLE);
        cnt_dec = cnt_q - CNT_ONE;
        under   = (cnt_dec > base_q);
        cond    = !mask && (hw_req || sreq_q) && !xfer_disable;
        kill    = end_req && !single && started_q;
        no_data = (mode_q.xm == XM_CASCADE) || (mode_q.dir == DIR_MEM2MEM);
        elig    = started_q && cond && (cnt_q <= base_q) && !no_data && !kill;
        tc_hit  = grant && under;
        end_seq = kill || (grant && (under || !hw_req));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            addr_q    <= '0;
            cnt_q     <= '0;
            base_q    <= '0;
            started_q <= 1'b0;
            sreq_q    <= 1'b0;
            cond_q    <= 1'b0;
        end else begin
            cond_q    <= cond;
            started_q <= cond && (started_q || !cond_q) && !end_seq;
            sreq_q    <= (sreq_q && !end_seq) || sw_set;
            if (cfg_we) begin
                mode_q <= cfg_mode;
                addr_q <= cfg_addr;
                cnt_q  <= cfg_cnt;
                base_q <= cfg_cnt;
            end else if (grant) begin
                addr_q <= step_addr(addr_q, mode_q.word, wrap_en);
                cnt_q  <= cnt_dec;
            end
        end
    end

    assign cur_addr = addr_q;
    assign mode_o   = mode_q;
    assign started  = started_q;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [4:0]        cfg_mode,
    input  logic              xfer_disable,
    input  logic              fast_timing,
    input  logic              wrap_en,
    input  logic              svc_tick,
    input  logic [NCH-1:0]    hw_req,
    input  logic [NCH-1:0]    sw_req_set,
    input  logic [NCH-1:0]    mask,
    input  logic [NCH-1:0]    end_req,
    output logic              xfer_valid,
    output logic [CH_W-1:0]   xfer_ch,
    output logic              xfer_word,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [WAIT_W-1:0] wait_cycles,
    output logic [NCH-1:0]    tc_pulse,
    output logic [NCH-1:0]    ch_started
);
    logic [NCH-1:0]    elig, req, grant, tc_hit;
    logic [ADDR_W-1:0] ch_addr [NCH];
    mode_t             ch_mode [NCH];
    logic [CH_W-1:0]   pick_idx;
    logic              pick_any;
    mode_t             sel_mode;
    strobe_t           sel_st;

    assign req = svc_tick ? elig : '0;

    dma_pick #(.NCH(NCH), .IDX_W(CH_W)) u_pick (
        .req   (req),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan #(.CNT_W(CNT_W)) u_chan (
            .clk          (clk),
            .rst          (rst),
            .cfg_we       (cfg_we && (cfg_ch == CH_W'(g))),
            .cfg_addr     (cfg_addr),
            .cfg_cnt      (cfg_count),
            .cfg_mode     (mode_t'(cfg_mode)),
            .hw_req       (hw_req[g]),
            .sw_set       (sw_req_set[g]),
            .mask         (mask[g]),
            .end_req      (end_req[g]),
            .xfer_disable (xfer_disable),
            .wrap_en      (wrap_en),
            .grant        (grant[g]),
            .elig         (elig[g]),
            .cur_addr     (ch_addr[g]),
            .mode_o       (ch_mode[g]),
            .tc_hit       (tc_hit[g]),
            .started      (ch_started[g])
        );
    end

    assign sel_mode = ch_mode[pick_idx];
    assign sel_st   = dir_strobes(sel_mode.dir);

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_valid  <= 1'b0;
            xfer_ch     <= '0;
            xfer_word   <= 1'b0;
            mem_rd      <= 1'b0;
            mem_wr      <= 1'b0;
            dev_rd      <= 1'b0;
            dev_wr      <= 1'b0;
            xfer_addr   <= '0;
            wait_cycles <= '0;
            tc_pulse    <= '0;
        end else begin
            xfer_valid <= pick_any;
            tc_pulse   <= tc_hit;
            if (pick_any) begin
                xfer_ch     <= pick_idx;
                xfer_word   <= sel_mode.word;
                xfer_addr   <= ch_addr[pick_idx];
                mem_rd      <= sel_st.mem_rd;
                mem_wr      <= sel_st.mem_wr;
                dev_rd      <= sel_st.dev_rd;
                dev_wr      <= sel_st.dev_wr;
                wait_cycles <= fast_timing ? WAIT_FAST : WAIT_SLOW;
            end else begin
                mem_rd      <= 1'b0;
                mem_wr      <= 1'b0;
                dev_rd      <= 1'b0;
                dev_wr      <= 1'b0;
                wait_cycles <= '0;
            end
        end
    end
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              svc_tick,
    input logic              xfer_disable,
    input logic [NCH-1:0]    mask,
    input logic              xfer_valid,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              dev_rd,
    input logic              dev_wr,
    input logic [WAIT_W-1:0] wait_cycles,
    input logic [NCH-1:0]    tc_pulse
);
    // R1
    all_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_tick && (&mask)) |=> !xfer_valid);

    // R2
    no_service_chk: assert property (@(posedge clk) disable iff (rst)
        (!svc_tick || xfer_disable) |=> !xfer_valid);

    // R3
    single_writer_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr && dev_wr));

    // R3
    idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_valid |-> !(mem_rd || mem_wr || dev_rd || dev_wr));

    // R3
    reads_one_side_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (mem_rd || dev_rd));

    // R10
    wait_value_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (wait_cycles == WAIT_FAST || wait_cycles == WAIT_SLOW));

    // R11
    tc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tc_pulse));

    // R6
    tc_with_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse != '0) |-> xfer_valid);
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .svc_tick     (svc_tick),
    .xfer_disable (xfer_disable),
    .mask         (mask),
    .xfer_valid   (xfer_valid),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .dev_rd       (dev_rd),
    .dev_wr       (dev_wr),
    .wait_cycles  (wait_cycles),
    .tc_pulse     (tc_pulse)
);

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;
    import dma_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [31:0] cfg_addr = '0;
    logic [15:0] cfg_count = '0;
    logic [4:0]  cfg_mode = '0;
    logic        xfer_disable = 1'b0, fast_timing = 1'b0, wrap_en = 1'b0, svc_tick = 1'b0;
    logic [3:0]  hw_req = '0, sw_req_set = '0, mask = '0, end_req = '0;
    logic        xfer_valid, xfer_word, mem_rd, mem_wr, dev_rd, dev_wr;
    logic [1:0]  xfer_ch;
    logic [31:0] xfer_addr;
    logic [2:0]  wait_cycles;
    logic [3:0]  tc_pulse, ch_started;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dma_xfer_seq u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_mode(cfg_mode), .xfer_disable(xfer_disable),
        .fast_timing(fast_timing), .wrap_en(wrap_en), .svc_tick(svc_tick),
        .hw_req(hw_req), .sw_req_set(sw_req_set), .mask(mask), .end_req(end_req),
        .xfer_valid(xfer_valid), .xfer_ch(xfer_ch), .xfer_word(xfer_word),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .xfer_addr(xfer_addr), .wait_cycles(wait_cycles), .tc_pulse(tc_pulse),
        .ch_started(ch_started)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input logic [31:0] a, input logic [15:0] n,
                       input logic [4:0] m);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_addr = a; cfg_count = n; cfg_mode = m;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic tick(input logic s);
        svc_tick = s;
        @(posedge clk); #1;
        svc_tick = 1'b0;
    endtask

    task automatic expect_xfer(input string r, input int ch, input logic w,
                               input logic [3:0] st, input logic [31:0] a,
                               input logic [3:0] tc);
        logic [2:0] wt;
        wt = fast_timing ? 3'd5 : 3'd7;
        chk(r, 64'({xfer_valid, xfer_ch, xfer_word, mem_rd, mem_wr, dev_rd, dev_wr,
                    wait_cycles, tc_pulse}),
               64'({1'b1, 2'(ch), w, st, wt, tc}));
        chk(r, 64'(xfer_addr), 64'(a));
    endtask

    task automatic expect_idle(input string r);
        chk(r, 64'({xfer_valid, mem_rd, mem_wr, dev_rd, dev_wr, wait_cycles, tc_pulse}),
               64'(0));
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk("R1", 64'({xfer_valid, tc_pulse, ch_started, wait_cycles}), 64'(0));

        // R4 R6 R10: sweep size, width and timing on channel 0, device to memory
        for (int w = 0; w < 2; w++) begin
            for (int f = 0; f < 2; f++) begin
                for (int n = 0; n < 5; n++) begin
                    logic [31:0] base;
                    base = 32'h1000 + 32'(n * 16);
                    fast_timing = f[0];
                    cfg(0, base, 16'(n), {2'b10, 2'b01, w[0]});
                    hw_req[0] = 1'b1;
                    tick(1'b0);
                    for (int k = 0; k <= n; k++) begin
                        tick(1'b1);
                        expect_xfer("R4/R6/R10", 0, w[0], 4'b0110,
                                    base + 32'(k * (w + 1)),
                                    (k == n) ? 4'b0001 : 4'b0000);
                    end
                    tick(1'b1);
                    expect_idle("R12");
                    hw_req[0] = 1'b0;
                    tick(1'b0);
                end
            end
        end
        fast_timing = 1'b0;

        // R5: wrap on and off
        wrap_en = 1'b1;
        cfg(0, 32'h12FF_FFFF, 16'd1, {2'b10, 2'b01, 1'b1});
        hw_req[0] = 1'b1; tick(1'b0);
        tick(1'b1); expect_xfer("R5", 0, 1'b1, 4'b0110, 32'h12FF_FFFF, 4'b0000);
        tick(1'b1); expect_xfer("R5", 0, 1'b1, 4'b0110, 32'h1200_0001, 4'b0001);
        hw_req[0] = 1'b0; tick(1'b0);
        cfg(0, 32'h34FF_FFFF, 16'd1, {2'b10, 2'b01, 1'b0});
        hw_req[0] = 1'b1; tick(1'b0);
        tick(1'b1); expect_xfer("R5", 0, 1'b0, 4'b0110, 32'h34FF_FFFF, 4'b0000);
        tick(1'b1); expect_xfer("R5", 0, 1'b0, 4'b0110, 32'h3400_0000, 4'b0001);
        hw_req[0] = 1'b0; tick(1'b0);
        wrap_en = 1'b0;
        cfg(0, 32'h12FF_FFFF, 16'd1, {2'b10, 2'b01, 1'b1});
        hw_req[0] = 1'b1; tick(1'b0);
        tick(1'b1); expect_xfer("R5", 0, 1'b1, 4'b0110, 32'h12FF_FFFF, 4'b0000);
        tick(1'b1); expect_xfer("R5", 0, 1'b1, 4'b0110, 32'h1300_0001, 4'b0001);
        hw_req[0] = 1'b0; tick(1'b0);

        // R11: lowest channel first, one transfer per tick
        cfg(1, 32'h200, 16'd1, {2'b00, 2'b01, 1'b0});
        cfg(2, 32'h300, 16'd0, {2'b00, 2'b01, 1'b0});
        hw_req = 4'b0110; tick(1'b0);
        tick(1'b1); expect_xfer("R11", 1, 1'b0, 4'b0110, 32'h200, 4'b0000);
        tick(1'b1); expect_xfer("R11", 1, 1'b0, 4'b0110, 32'h201, 4'b0010);
        tick(1'b1); expect_xfer("R11", 2, 1'b0, 4'b0110, 32'h300, 4'b0100);
        tick(1'b1); expect_idle("R11");
        hw_req = 4'b0000; tick(1'b0);

        // R1 mask, R3 verify strobes
        cfg(3, 32'h500, 16'd3, {2'b10, 2'b00, 1'b0});
        mask = 4'b1000; hw_req = 4'b1000; tick(1'b0);
        tick(1'b1); expect_idle("R1");
        chk("R1", 64'(ch_started[3]), 64'(0));
        mask = 4'b0000;
        tick(1'b1); expect_idle("R1");
        chk("R1", 64'(ch_started[3]), 64'(1));
        tick(1'b1); expect_xfer("R1/R3", 3, 1'b0, 4'b1010, 32'h500, 4'b0000);
        hw_req = 4'b0000; tick(1'b0);
        chk("R1", 64'(ch_started[3]), 64'(0));

        // R2 disable, R3 memory to device
        cfg(0, 32'h600, 16'd2, {2'b10, 2'b10, 1'b0});
        xfer_disable = 1'b1; hw_req[0] = 1'b1; tick(1'b0);
        tick(1'b1); expect_idle("R2");
        xfer_disable = 1'b0; tick(1'b0);
        tick(1'b1); expect_xfer("R2/R3", 0, 1'b0, 4'b1001, 32'h600, 4'b0000);
        hw_req[0] = 1'b0; tick(1'b0);

        // R9: software request alone gives one transfer
        cfg(1, 32'h700, 16'd5, {2'b00, 2'b01, 1'b0});
        sw_req_set = 4'b0010; tick(1'b0);
        sw_req_set = 4'b0000; tick(1'b0);
        tick(1'b1); expect_xfer("R9", 1, 1'b0, 4'b0110, 32'h700, 4'b0000);
        tick(1'b1); expect_idle("R9");

        // R8: end request in demand mode ends the channel
        cfg(2, 32'h800, 16'd5, {2'b00, 2'b01, 1'b0});
        hw_req[2] = 1'b1; tick(1'b0);
        tick(1'b1); expect_xfer("R8", 2, 1'b0, 4'b0110, 32'h800, 4'b0000);
        end_req[2] = 1'b1;
        tick(1'b1); expect_idle("R8");
        end_req[2] = 1'b0;
        tick(1'b1); expect_idle("R8");
        hw_req[2] = 1'b0; tick(1'b0);

        // R8: end request ignored in single mode
        cfg(2, 32'h900, 16'd5, {2'b01, 2'b01, 1'b0});
        hw_req[2] = 1'b1; tick(1'b0);
        end_req[2] = 1'b1;
        tick(1'b1); expect_xfer("R8", 2, 1'b0, 4'b0110, 32'h900, 4'b0000);
        tick(1'b1); expect_xfer("R8", 2, 1'b0, 4'b0110, 32'h901, 4'b0000);
        end_req[2] = 1'b0; hw_req[2] = 1'b0; tick(1'b0);

        // R7: cascade and memory to memory move no data
        cfg(0, 32'hA00, 16'd3, {2'b11, 2'b01, 1'b0});
        hw_req[0] = 1'b1; tick(1'b0);
        tick(1'b1); expect_idle("R7");
        hw_req[0] = 1'b0; tick(1'b0);
        cfg(0, 32'hA00, 16'd3, {2'b10, 2'b11, 1'b0});
        hw_req[0] = 1'b1; tick(1'b0);
        tick(1'b1); expect_idle("R7");
        hw_req[0] = 1'b0; tick(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule